// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses of one SDRAM burst, one per beat. A controller pulses `start_i` with the first column, a 3-bit burst-length code and an ordering select. From the next cycle the block presents the first column with `valid_o` high. Each cycle with `advance_i` high moves it to the next beat. `last_o` marks the final beat of a finite burst. When that beat is advanced, the burst ends and `valid_o` drops.

Finite bursts of 1, 2, 4 or 8 beats stay inside the aligned block of that size. Sequential ordering adds the beat number to the start column and wraps inside the block. Interleaved ordering XORs the beat number into the start column. A full-page burst walks the whole row of 2^COL_W columns, wrapping from the top column to column 0. It runs until `stop_i` is pulsed. A controller uses `stop_i` for a burst stop, or for the early end of a burst when a precharge cuts it off. Reserved length codes run as single-beat bursts and raise `cfg_err_o`.

The controller has three states. IDLE goes to BURST on a start with a finite length, and to PAGE on a start with the full-page code. BURST returns to IDLE when the final beat is advanced or when a stop arrives. PAGE returns to IDLE only on a stop. In BURST and PAGE, a start restarts the sequence and wins over a stop and an advance. A stop wins over an advance.

Top module: `burst_addr_gen`

## Requirements
- R1: During and right after reset, `valid_o`, `last_o` and `cfg_err_o` are 0.
- R2: The cycle after `start_i` is sampled high, `valid_o` is 1 and `col_o` equals the sampled `start_col_i`, whatever the state.
- R3: With `order_i`=0 and a finite length L, beat n is at column (start & ~(L-1)) | ((start + n) mod L); the bits above the block never change.
- R4: With `order_i`=1 and a finite length L, beat n is at column start XOR n; the bits above the block never change.
- R5: `len_code_i` encodes 000=1 beat, 001=2, 010=4, 011=8, 111=full page. These two fields are sampled only with `start_i`.
- R6: `last_o` is 1 exactly on beat L-1 of a finite burst. Advancing that beat makes `valid_o` 0 in the next cycle.
- R7: While `advance_i`, `start_i` and `stop_i` are low during a burst, `col_o`, `valid_o` and `last_o` hold.
- R8: A full-page burst steps the column by one modulo 2^COL_W on each advance. It never raises `last_o` and runs until stopped.
- R9: `stop_i` sampled high without `start_i` during a burst makes `valid_o` 0 in the next cycle. Any advance in that cycle is ignored.
- R10: A full-page start with `order_i`=1 runs in sequential order.
- R11: A reserved length code (100, 101, 110) runs a single-beat burst with `last_o` high and `cfg_err_o` = 1. `cfg_err_o` stays 1 until the next start with a valid code.
- R12: A start during a running burst drops the old sequence and begins the new one from beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst with the fields below |
| advance_i | input | 1 | Move to the next beat |
| stop_i | input | 1 | End the running burst |
| start_col_i | input | COL_W | First column of the burst |
| len_code_i | input | 3 | Burst-length code |
| order_i | input | 1 | 0 sequential, 1 interleaved |
| col_o | output | COL_W | Column of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Current beat is the final one of a finite burst |
| cfg_err_o | output | 1 | The burst was started with a reserved length code |

## Verification
On every cycle, the assertions check the handshake-level rules. These are: the first column after a start, the hold while idle inputs are low, the end of the burst after a stop or after the final beat is advanced, `last_o` never appearing without `valid_o`, and the single-beat error burst. The column orderings can only be shown by the bench's scenarios. Those scenarios cover every start offset for every finite length and both orderings, a full-page run past the wrap point, interleave-with-page fallback and restarts mid-burst. A behavioural reference model, compared on every clock, checks each of them.

// File: rtl/burst_gen_pkg.sv
package burst_gen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_PAGE  = 2'd2
    } seq_state_t;

    localparam int LOG_W = 5;

    typedef struct packed {
        logic [LOG_W-1:0] len_log;   // log2 of beats; COL_W for a full page
        logic             page;
        logic             xor_mode;
        logic             bad_code;
    } burst_cfg_t;

    localparam logic [2:0] CODE_L1   = 3'b000;
    localparam logic [2:0] CODE_L2   = 3'b001;
    localparam logic [2:0] CODE_L4   = 3'b010;
    localparam logic [2:0] CODE_L8   = 3'b011;
    localparam logic [2:0] CODE_PAGE = 3'b111;

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
    import burst_gen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [2:0]  code_i,
    input  logic        order_i,
    output burst_cfg_t  cfg_o
);

    always_comb begin
        cfg_o = '0;
        unique case (code_i)
            CODE_L1: cfg_o.len_log = LOG_W'(0);
            CODE_L2: cfg_o.len_log = LOG_W'(1);
            CODE_L4: cfg_o.len_log = LOG_W'(2);
            CODE_L8: cfg_o.len_log = LOG_W'(3);
            CODE_PAGE: begin
                cfg_o.len_log = LOG_W'(COL_W);
                cfg_o.page    = 1'b1;
            end
            default: begin
                cfg_o.len_log  = LOG_W'(0);
                cfg_o.bad_code = 1'b1;
            end
        endcase
        // interleave has no meaning over a whole row
        cfg_o.xor_mode = order_i && !cfg_o.page;
    end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    output logic [COL_W-1:0] beat_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_o <= '0;
        end else if (clear_i) begin
            beat_o <= '0;
        end else if (step_i) begin
            beat_o <= beat_o + COL_W'(1);
        end
    end

endmodule

// File: rtl/burst_col_map.sv
module burst_col_map
    import burst_gen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [LOG_W-1:0] len_log_i,
    input  logic             xor_mode_i,
    output logic [COL_W-1:0] mask_o,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] summed;
    logic [COL_W-1:0] mixed;

    for (genvar g = 0; g < COL_W; g++) begin : g_mask
        assign mask_o[g] = (len_log_i > LOG_W'(g));
    end

    always_comb begin
        summed = base_i + beat_i;
        mixed  = xor_mode_i ? (base_i ^ beat_i) : summed;
        col_o  = (base_i & ~mask_o) | (mixed & mask_o);
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_gen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             advance_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             order_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             cfg_err_o
);

    seq_state_t       state_q, state_d;
    burst_cfg_t       cfg_new, cfg_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] mask;
    logic             at_end;
    logic             step;

    burst_len_decode #(.COL_W(COL_W)) u_dec (
        .code_i  (len_code_i),
        .order_i (order_i),
        .cfg_o   (cfg_new)
    );

    burst_beat_ctr #(.COL_W(COL_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_i),
        .step_i  (step),
        .beat_o  (beat)
    );

    burst_col_map #(.COL_W(COL_W)) u_map (
        .base_i     (base_q),
        .beat_i     (beat),
        .len_log_i  (cfg_q.len_log),
        .xor_mode_i (cfg_q.xor_mode),
        .mask_o     (mask),
        .col_o      (col_o)
    );

    assign at_end = (state_q == ST_BURST) && (beat == mask);
    assign step   = advance_i && !stop_i && (state_q != ST_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = cfg_new.page ? ST_PAGE : ST_BURST;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_BURST: if (stop_i || (advance_i && at_end)) state_d = ST_IDLE;
                ST_PAGE:  if (stop_i) state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register and captured burst fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            base_q  <= '0;
        end else begin
            state_q <= state_d;
            if (start_i) begin
                cfg_q  <= cfg_new;
                base_q <= start_col_i;
            end
        end
    end

    // outputs
    always_comb begin
        valid_o   = 1'b0;
        last_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_BURST: begin
                valid_o = 1'b1;
                last_o  = at_end;
            end
            ST_PAGE:  valid_o = 1'b1;
            default:  ;
        endcase
        cfg_err_o = cfg_q.bad_code;
    end

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             advance_i,
    input logic             stop_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [2:0]       len_code_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o,
    input logic             cfg_err_o
);

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !valid_o && !last_o && !cfg_err_o); // R1

    AST_START_FIRST_COL: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o && (col_o == $past(start_col_i))); // R2

    AST_HOLD_IDLE_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !advance_i && !start_i && !stop_i |=> valid_o && $stable(col_o) && $stable(last_o)); // R7

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i && !start_i |=> !valid_o); // R9

    AST_FINAL_BEAT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        last_o && advance_i && !start_i |=> !valid_o); // R6

    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o); // R6

    AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && (len_code_i == 3'b111) |=> !last_o); // R8

    AST_RESERVED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && (len_code_i inside {3'b100, 3'b101, 3'b110}) |=> cfg_err_o && last_o); // R11

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .advance_i   (advance_i),
    .stop_i      (stop_i),
    .start_col_i (start_col_i),
    .len_code_i  (len_code_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o),
    .cfg_err_o   (cfg_err_o)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

    localparam int COL_W = 8;
    localparam int ROW   = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             advance_i = 1'b0;
    logic             stop_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       len_code_i = '0;
    logic             order_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o, last_o, cfg_err_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    bit m_active = 0;
    bit m_page = 0;
    bit m_il = 0;
    bit m_err = 0;
    int m_s = 0;
    int m_len = 1;
    int m_n = 0;

    always #4 clk = ~clk;

    burst_addr_gen #(.COL_W(COL_W)) u_dut (
        .clk, .rst_n, .start_i, .advance_i, .stop_i, .start_col_i,
        .len_code_i, .order_i, .col_o, .valid_o, .last_o, .cfg_err_o
    );

    function automatic int exp_col();
        int blk;
        if (m_page) return (m_s + m_n) % ROW;
        blk = (m_s / m_len) * m_len;
        if (m_il) return blk + ((m_s % m_len) ^ m_n);
        return blk + ((m_s % m_len + m_n) % m_len);
    endfunction

    task automatic model_step();
        if (start_i) begin
            m_active = 1; m_s = int'(start_col_i); m_n = 0; m_err = 0; m_page = 0;
            case (len_code_i)
                3'd0: m_len = 1;
                3'd1: m_len = 2;
                3'd2: m_len = 4;
                3'd3: m_len = 8;
                3'd7: begin m_len = ROW; m_page = 1; end
                default: begin m_len = 1; m_err = 1; end
            endcase
            m_il = order_i && !m_page;
        end else if (m_active) begin
            if (stop_i) m_active = 0;
            else if (advance_i) begin
                if (!m_page && m_n == m_len - 1) m_active = 0;
                else m_n = (m_n + 1) % ROW;
            end
        end
    endtask

    task automatic check_bit(string tag, string what, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %0b expected %0b", tag, what, got, exp);
        end
    endtask

    task automatic compare(string tag);
        bit exp_last;
        exp_last = m_active && !m_page && (m_n == m_len - 1);
        check_bit(tag, "valid", valid_o, m_active);
        check_bit(tag, "last", last_o, exp_last);
        check_bit("R11", "cfg_err", cfg_err_o, m_err);
        if (m_active) begin
            checks++;
            if (int'(col_o) != exp_col()) begin
                errors++;
                $display("FAIL %s col got %0d expected %0d", tag, col_o, exp_col());
            end
        end
    endtask

    task automatic drive(bit st, bit adv, bit stp, int col, int code, bit typ, string tag);
        start_i = st; advance_i = adv; stop_i = stp;
        start_col_i = COL_W'(col); len_code_i = 3'(code); order_i = typ;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic run_burst(int col, int code, bit typ, string tag);
        drive(1, 0, 0, col, code, typ, tag);
        for (int k = 0; k < 20 && m_active; k++) drive(0, 1, 0, 0, 0, 0, tag);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");

        // R2 R3 R4 R5 R6: every offset, every finite length, both orders
        for (int code = 0; code < 4; code++) begin
            for (int typ = 0; typ < 2; typ++) begin
                for (int off = 0; off < 8; off++) begin
                    int col;
                    col = (code[0] ? 8'h58 : 8'hC8) + off;
                    if (typ == 0) run_burst(col, code, 1'b0, "R2 R3 R5 R6");
                    else          run_burst(col, code, 1'b1, "R2 R4 R5 R6");
                end
            end
        end

        // R7: stalls in the middle of a burst
        drive(1, 0, 0, 8'h3D, 3, 0, "R7");
        for (int k = 0; k < 12 && m_active; k++) drive(0, k % 3 == 2, 0, 0, 0, 0, "R7");
        drive(0, 0, 0, 0, 0, 0, "R7");

        // R8: full page across the row wrap, then R9 stop
        drive(1, 0, 0, 8'hFA, 7, 0, "R8");
        for (int k = 0; k < ROW + 6; k++) drive(0, 1, 0, 0, 0, 0, "R8");
        drive(0, 1, 1, 0, 0, 0, "R9");
        drive(0, 1, 0, 0, 0, 0, "R9");

        // R10: interleave requested with full page
        drive(1, 0, 0, 8'h35, 7, 1, "R10");
        for (int k = 0; k < 20; k++) drive(0, 1, 0, 0, 0, 0, "R10");
        drive(0, 0, 1, 0, 0, 0, "R9");

        // R11: reserved codes, then cleared by a valid start
        for (int code = 4; code < 7; code++) begin
            run_burst(8'h47, code, 0, "R11");
            drive(0, 0, 0, 0, 0, 0, "R11");
        end
        run_burst(8'h12, 1, 0, "R11");

        // R12: restart mid-burst, including finite into page and back
        drive(1, 0, 0, 8'h21, 3, 0, "R12");
        drive(0, 1, 0, 0, 0, 0, "R12");
        drive(0, 1, 0, 0, 0, 0, "R12");
        drive(1, 1, 1, 8'h96, 2, 1, "R12");
        drive(0, 1, 0, 0, 0, 0, "R12");
        drive(1, 1, 0, 8'hFF, 7, 0, "R12");
        drive(0, 1, 0, 0, 0, 0, "R12");
        run_burst(8'h0B, 3, 1, "R12");

        // R9: stop in the middle of a finite burst
        drive(1, 0, 0, 8'h74, 3, 0, "R9");
        drive(0, 1, 0, 0, 0, 0, "R9");
        drive(0, 1, 1, 0, 0, 0, "R9");
        drive(0, 1, 0, 0, 0, 0, "R9");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule